// File: doc/BRIEF.md
# Single-Entry Loop Branch Predictor

This block sits beside instruction fetch and makes tight loops cheap. It keeps exactly one remembered conditional branch: the most recent one that was taken and jumped backward. When fetch presents that same address again, the block signals a hit and returns the remembered target, so fetch can go there straight away. Every other address is treated as a branch that will not be taken.

When execute resolves a conditional branch, it presents the branch address, its signed offset, whether it was taken, whether fetch had predicted it taken, and the sizes of the branch and of its target instruction. The block derives the target and the direction from the offset and updates its entry. One cycle later it reports whether fetch must be redirected, the address to redirect to, and how many cycles the branch costs. A pipeline flush, such as a trap, empties the entry.

Top module: `loop_branch_predictor`

## Requirements
- R1: After reset the entry is empty: `pred_hit_o` is 0 for every fetch address and `res_vld_o` is 0.
- R2: A resolved branch with `ex_taken_i`=1 and a negative offset (bit OFF_W-1 of `ex_off_i` set) is stored. From the next cycle a fetch at its address gives `pred_hit_o`=1 and `pred_tgt_o` = branch address + sign-extended offset.
- R3: A fetch whose address differs from the stored branch, or with `fetch_vld_i`=0, gives `pred_hit_o`=0.
- R4: A taken branch with a non-negative offset leaves the entry unchanged: the stored branch still hits and the forward branch does not.
- R5: A branch resolved with `ex_pred_i`=1 and `ex_taken_i`=0 empties the entry, so the next fetch at that address gives `pred_hit_o`=0.
- R6: A newer taken backward branch replaces the older entry; the older address no longer hits.
- R7: `flush_i`=1 empties the entry in the next cycle. It wins over a fill resolved in the same cycle.
- R8: `res_vld_o` is 1 in exactly the cycle after a cycle with `ex_vld_i`=1. At that point, `res_mispred_o` is 1 when `ex_pred_i` differed from `ex_taken_i`.
- R9: `res_pc_o` holds the branch target when the branch was taken. When it was not taken, it holds the fall-through address: branch address + 4 if `ex_len32_i`=1, otherwise + 2.
- R10: `res_cost_o` is 1, plus 1 on a mispredict, plus 1 when the branch was taken, `ex_tgt32_i`=1 and target bit 1 is set (a 32-bit target not on a 4-byte boundary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Pipeline flush; empties the entry |
| fetch_vld_i | input | 1 | Fetch address is valid this cycle |
| fetch_pc_i | input | ADDR_W | Fetch address to look up |
| pred_hit_o | output | 1 | Fetch address matches the stored branch |
| pred_tgt_o | output | ADDR_W | Stored target to fetch next on a hit |
| ex_vld_i | input | 1 | A branch resolves this cycle |
| ex_pc_i | input | ADDR_W | Address of the resolving branch |
| ex_off_i | input | OFF_W | Signed branch offset |
| ex_taken_i | input | 1 | Branch was taken |
| ex_pred_i | input | 1 | Fetch had predicted this branch taken |
| ex_len32_i | input | 1 | Branch instruction is 32 bits long |
| ex_tgt32_i | input | 1 | Target instruction is 32 bits long |
| res_vld_o | output | 1 | Resolution report valid |
| res_mispred_o | output | 1 | Fetch must be redirected |
| res_pc_o | output | ADDR_W | Correct next address |
| res_cost_o | output | 2 | Cycles spent on the branch |

## Verification
The assertions assume that execute resolves at most one branch per cycle. They also assume that `ex_pred_i` is only high for a branch that hit when it was fetched, so a taken/not-taken disagreement always refers to the branch held in the entry. The bench keeps to this. It raises `ex_pred_i` only for the address its own model says is stored, and it keeps branch addresses on 2-byte boundaries. It steps through fills, forward jumps, replacements, mispredicts and flushes in separate directed tasks.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  typedef logic [1:0] cost_t;

  // extra fetch cycle when a taken branch lands on a 32-bit instruction
  // that straddles a 4-byte boundary
  function automatic logic split_target(logic taken, logic tgt32, logic tgt_b1);
    return taken & tgt32 & tgt_b1;
  endfunction

  function automatic cost_t branch_cost(logic mispred, logic split);
    return cost_t'(2'd1 + {1'b0, mispred} + {1'b0, split});
  endfunction

endpackage

// File: rtl/lbp_entry.sv
module lbp_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              fill_en_i,
  input  logic [ADDR_W-1:0] fill_pc_i,
  input  logic [ADDR_W-1:0] fill_tgt_i,
  input  logic              kill_en_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] tgt_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      pc_o  <= '0;
      tgt_o <= '0;
    end else if (flush_i) begin
      vld_o <= 1'b0;
    end else if (fill_en_i) begin
      vld_o <= 1'b1;
      pc_o  <= fill_pc_i;
      tgt_o <= fill_tgt_i;
    end else if (kill_en_i) begin
      vld_o <= 1'b0;
    end
  end

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !vld_o);

  assert_fill_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !flush_i) |=> (vld_o && pc_o == $past(fill_pc_i) && tgt_o == $past(fill_tgt_i)));

  assert_kill_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en_i && !fill_en_i) |=> !vld_o);

endmodule

// File: rtl/lbp_lookup.sv
module lbp_lookup #(
  parameter int ADDR_W = 32
) (
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              ent_vld_i,
  input  logic [ADDR_W-1:0] ent_pc_i,
  input  logic [ADDR_W-1:0] ent_tgt_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] tgt_o
);

  logic addr_match;

  always_comb begin
    addr_match = (fetch_pc_i == ent_pc_i);
    hit_o      = fetch_vld_i & ent_vld_i & addr_match;
    tgt_o      = ent_tgt_i;
  end

  always_comb begin
    assert_hit_only_when_stored_R3: assert (!hit_o || ent_vld_i);
  end

endmodule

// File: rtl/lbp_resolve.sv
module lbp_resolve
  import lbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_vld_i,
  input  logic [ADDR_W-1:0] ex_pc_i,
  input  logic [OFF_W-1:0]  ex_off_i,
  input  logic              ex_taken_i,
  input  logic              ex_pred_i,
  input  logic              ex_len32_i,
  input  logic              ex_tgt32_i,
  output logic              fill_en_o,
  output logic              kill_en_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              backward_o,
  output logic              res_vld_o,
  output logic              res_mispred_o,
  output logic [ADDR_W-1:0] res_pc_o,
  output cost_t             res_cost_o
);

  localparam int EXT_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] target_of(logic [ADDR_W-1:0] pc,
                                                  logic [OFF_W-1:0]  off);
    return pc + {{EXT_W{off[OFF_W-1]}}, off};
  endfunction

  function automatic logic [ADDR_W-1:0] fallthru_of(logic [ADDR_W-1:0] pc,
                                                    logic len32);
    return pc + (len32 ? ADDR_W'(4) : ADDR_W'(2));
  endfunction

  logic              mispred;
  logic              split;
  logic [ADDR_W-1:0] next_pc;

  always_comb begin
    tgt_o      = target_of(ex_pc_i, ex_off_i);
    backward_o = ex_off_i[OFF_W-1];
    fill_en_o  = ex_vld_i & ex_taken_i & backward_o;
    kill_en_o  = ex_vld_i & ex_pred_i & ~ex_taken_i;
    mispred    = ex_pred_i ^ ex_taken_i;
    split      = split_target(ex_taken_i, ex_tgt32_i, tgt_o[1]);
    next_pc    = ex_taken_i ? tgt_o : fallthru_of(ex_pc_i, ex_len32_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld_o     <= 1'b0;
      res_mispred_o <= 1'b0;
      res_pc_o      <= '0;
      res_cost_o    <= '0;
    end else begin
      res_vld_o <= ex_vld_i;
      if (ex_vld_i) begin
        res_mispred_o <= mispred;
        res_pc_o      <= next_pc;
        res_cost_o    <= branch_cost(mispred, split);
      end
    end
  end

  assert_report_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_vld_i |=> res_vld_o);

  assert_no_stray_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_vld_i |=> !res_vld_o);

  assert_mispred_costs_more_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_mispred_o) |-> (res_cost_o >= 2'd2));

endmodule

// File: rtl/loop_branch_predictor.sv
module loop_branch_predictor
  import lbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              pred_hit_o,
  output logic [ADDR_W-1:0] pred_tgt_o,
  input  logic              ex_vld_i,
  input  logic [ADDR_W-1:0] ex_pc_i,
  input  logic [OFF_W-1:0]  ex_off_i,
  input  logic              ex_taken_i,
  input  logic              ex_pred_i,
  input  logic              ex_len32_i,
  input  logic              ex_tgt32_i,
  output logic              res_vld_o,
  output logic              res_mispred_o,
  output logic [ADDR_W-1:0] res_pc_o,
  output cost_t             res_cost_o
);

  logic              fill_en;
  logic              kill_en;
  logic              is_backward;
  logic [ADDR_W-1:0] br_tgt;
  logic              ent_vld;
  logic [ADDR_W-1:0] ent_pc;
  logic [ADDR_W-1:0] ent_tgt;

  lbp_resolve #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_resolve (
    .clk           (clk),
    .rst_n         (rst_n),
    .ex_vld_i      (ex_vld_i),
    .ex_pc_i       (ex_pc_i),
    .ex_off_i      (ex_off_i),
    .ex_taken_i    (ex_taken_i),
    .ex_pred_i     (ex_pred_i),
    .ex_len32_i    (ex_len32_i),
    .ex_tgt32_i    (ex_tgt32_i),
    .fill_en_o     (fill_en),
    .kill_en_o     (kill_en),
    .tgt_o         (br_tgt),
    .backward_o    (is_backward),
    .res_vld_o     (res_vld_o),
    .res_mispred_o (res_mispred_o),
    .res_pc_o      (res_pc_o),
    .res_cost_o    (res_cost_o)
  );

  lbp_entry #(.ADDR_W(ADDR_W)) u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .fill_en_i  (fill_en),
    .fill_pc_i  (ex_pc_i),
    .fill_tgt_i (br_tgt),
    .kill_en_i  (kill_en),
    .vld_o      (ent_vld),
    .pc_o       (ent_pc),
    .tgt_o      (ent_tgt)
  );

  lbp_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .fetch_vld_i (fetch_vld_i),
    .fetch_pc_i  (fetch_pc_i),
    .ent_vld_i   (ent_vld),
    .ent_pc_i    (ent_pc),
    .ent_tgt_i   (ent_tgt),
    .hit_o       (pred_hit_o),
    .tgt_o       (pred_tgt_o)
  );

  assert_forward_keeps_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld_i && ex_taken_i && !is_backward && !flush_i)
      |=> ($stable(ent_vld) && $stable(ent_pc) && $stable(ent_tgt)));

  assert_no_hit_after_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !pred_hit_o);

  assert_no_hit_after_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en && !flush_i) |=> !pred_hit_o);

  assert_empty_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !pred_hit_o && !res_vld_o);

endmodule

// File: tb/loop_branch_predictor_tb.sv
module loop_branch_predictor_tb;

  localparam int AW = 32;
  localparam int OW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic          fetch_vld_i = 1'b0;
  logic [AW-1:0] fetch_pc_i = '0;
  logic          pred_hit_o;
  logic [AW-1:0] pred_tgt_o;
  logic          ex_vld_i = 1'b0;
  logic [AW-1:0] ex_pc_i = '0;
  logic [OW-1:0] ex_off_i = '0;
  logic          ex_taken_i = 1'b0;
  logic          ex_pred_i = 1'b0;
  logic          ex_len32_i = 1'b0;
  logic          ex_tgt32_i = 1'b0;
  logic          res_vld_o;
  logic          res_mispred_o;
  logic [AW-1:0] res_pc_o;
  logic [1:0]    res_cost_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench's own view of the stored branch
  logic          m_vld = 1'b0;
  logic [AW-1:0] m_pc  = '0;
  logic [AW-1:0] m_tgt = '0;

  always #5 clk = ~clk;

  loop_branch_predictor #(.ADDR_W(AW), .OFF_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .fetch_vld_i(fetch_vld_i), .fetch_pc_i(fetch_pc_i),
    .pred_hit_o(pred_hit_o), .pred_tgt_o(pred_tgt_o),
    .ex_vld_i(ex_vld_i), .ex_pc_i(ex_pc_i), .ex_off_i(ex_off_i),
    .ex_taken_i(ex_taken_i), .ex_pred_i(ex_pred_i),
    .ex_len32_i(ex_len32_i), .ex_tgt32_i(ex_tgt32_i),
    .res_vld_o(res_vld_o), .res_mispred_o(res_mispred_o),
    .res_pc_o(res_pc_o), .res_cost_o(res_cost_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // look up one address and compare against the bench model
  task automatic probe(string req, logic [AW-1:0] pc, logic vld);
    logic exp_hit;
    @(negedge clk);
    fetch_vld_i = vld;
    fetch_pc_i  = pc;
    #1;
    exp_hit = vld && m_vld && (m_pc == pc);
    check(req, 64'(pred_hit_o), 64'(exp_hit));
    if (exp_hit) check(req, 64'(pred_tgt_o), 64'(m_tgt));
    fetch_vld_i = 1'b0;
  endtask

  // resolve one branch, check the report, update the model
  task automatic resolve(string req, logic [AW-1:0] pc, int off, logic taken,
                         logic pred, logic len32, logic tgt32, logic flush);
    logic [AW-1:0] tgt, exp_pc;
    logic          mis, split;
    logic [1:0]    cost;
    tgt    = pc + AW'(off);
    mis    = pred != taken;
    split  = taken && tgt32 && tgt[1];
    cost   = 2'd1 + 2'(mis) + 2'(split);
    exp_pc = taken ? tgt : pc + (len32 ? 32'd4 : 32'd2);
    @(negedge clk);
    ex_vld_i   = 1'b1;
    ex_pc_i    = pc;
    ex_off_i   = OW'(off);
    ex_taken_i = taken;
    ex_pred_i  = pred;
    ex_len32_i = len32;
    ex_tgt32_i = tgt32;
    flush_i    = flush;
    @(posedge clk);
    #1;
    ex_vld_i = 1'b0;
    flush_i  = 1'b0;
    check({req, " R8 valid"},   64'(res_vld_o), 64'd1);
    check({req, " R8 mispred"}, 64'(res_mispred_o), 64'(mis));
    check({req, " R9 pc"},      64'(res_pc_o), 64'(exp_pc));
    check({req, " R10 cost"},   64'(res_cost_o), 64'(cost));
    if (flush) m_vld = 1'b0;
    else if (taken && off < 0) begin
      m_vld = 1'b1; m_pc = pc; m_tgt = tgt;
    end else if (pred && !taken) m_vld = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 hit after reset", 64'(pred_hit_o), 64'd0);
    check("R1 report after reset", 64'(res_vld_o), 64'd0);
    probe("R1 empty lookup", 32'h120, 1'b1);
  endtask

  task automatic t_fill();
    resolve("R2 fill", 32'h120, -32, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    probe("R2 hit stored", 32'h120, 1'b1);
    probe("R3 other pc", 32'h124, 1'b1);
    probe("R3 fetch idle", 32'h120, 1'b0);
  endtask

  task automatic t_forward();
    resolve("R4 forward", 32'h200, 64, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    probe("R4 old still hits", 32'h120, 1'b1);
    probe("R4 forward no hit", 32'h200, 1'b1);
  endtask

  task automatic t_correct();
    resolve("R10 correct taken", 32'h120, -32, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    resolve("R10 correct not taken", 32'h300, 16, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_replace_split();
    resolve("R6 R10 split target", 32'h130, -46, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    probe("R6 old gone", 32'h120, 1'b1);
    probe("R6 new hits", 32'h130, 1'b1);
    resolve("R10 16-bit target", 32'h130, -46, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_kill();
    resolve("R5 predicted not taken", 32'h130, -46, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    probe("R5 cleared", 32'h130, 1'b1);
  endtask

  task automatic t_flush();
    resolve("R7 refill", 32'h140, -16, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R7 refilled hits", 32'h140, 1'b1);
    @(negedge clk);
    flush_i = 1'b1;
    @(posedge clk);
    #1;
    flush_i = 1'b0;
    m_vld = 1'b0;
    probe("R7 flushed", 32'h140, 1'b1);
    resolve("R7 fill with flush", 32'h150, -8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R7 flush wins", 32'h150, 1'b1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R8 no report when idle", 64'(res_vld_o), 64'd0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_forward();
    t_correct();
    t_replace_split();
    t_kill();
    t_flush();
    t_idle();
    report();
  end

endmodule